// File: doc/BRIEF.md
# RTC Status and Flag Register Bank

This block keeps the control bits and sticky event flags of a real-time clock. Three byte-wide registers are reachable over a simple register-access port: a status byte, an interrupt-control byte and an oscillator-fail byte. That port carries an address, write data, a write strobe, a read strobe, a start pulse and a valid-stop pulse. Hardware inputs set the flags: battery-mode entry, an alarm-match pulse and an oscillator-absent level. Software clears the flags by writing zero to them. When enabled, the flags are also cleared automatically once a status read has finished with a valid bus stop.

The asynchronous active-low reset models a total loss of both supplies. After it, the block holds the timekeeping counters through `clk_run` until software writes at least one byte to a clock-register address. The clock registers themselves are outside this block. Only the writes to their addresses are observed here.

Top module: `rtc_flag_bank`

## Requirements
- R1: After reset the status byte (address 0x0B) reads 0x03, the oscillator byte (0x09) reads 0x80, the control byte (0x08) reads 0x00. Any address not listed reads 0x00.
- R2: Bit layout. Status: bit7 auto-clear enable, bit5 seal, bit2 alarm flag, bit1 battery flag, bit0 power-fail flag. Control: bit6 alarm enable, bit5 low-power. Oscillator byte: bit7 oscillator-fail flag. All other bits read 0. The control bits are written directly and also appear on the `auto_clr`, `seal`, `alarm_en` and `low_power` outputs.
- R3: The power-fail flag cannot be written. It clears on the first write to any clock-register address 0x00 to 0x06. While it is 1, `clk_run` is 0, and once cleared it stays 0 until reset.
- R4: Writing 1 to the battery, alarm or oscillator-fail flag leaves it unchanged. Writing 0 clears it.
- R5: The oscillator-fail flag is set in every cycle that `osc_absent` is 1. A write of 0 clears it only while `osc_absent` is 0.
- R6: The battery flag is set on the rising edge of `batt_mode`. Holding `batt_mode` high does not set it again after a clear.
- R7: An `alarm_hit` pulse sets the alarm flag only while alarm enable is 1.
- R8: With auto-clear enable at 1, a read of 0x0B followed by `bus_stop` clears the battery and alarm flags that the read returned as 1. With it at 0, a stop clears nothing.
- R9: A flag event arriving between the status read and its stop, or in the same cycle as a clearing stop or clearing write, leaves the flag set.
- R10: A `bus_start` (repeated start) or any write after the status read disarms the auto-clear. A later stop then clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low total-power-loss reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_start | input | 1 | Start or repeated-start pulse |
| bus_stop | input | 1 | Valid stop pulse |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| batt_mode | input | 1 | Device is running from the backup supply |
| alarm_hit | input | 1 | Alarm compare match pulse |
| osc_absent | input | 1 | Crystal oscillation missing |
| clk_run | output | 1 | Enables the timekeeping counters |
| alarm_en | output | 1 | Alarm enable control bit |
| low_power | output | 1 | Low-power supply-switch control bit |
| seal | output | 1 | Battery-saver seal control bit |
| auto_clr | output | 1 | Auto-clear enable control bit |

## Verification
The assertions assume that the strobes are single-cycle pulses from a bus engine. They also assume that `bus_stop` never coincides with a write to the status byte. Under these conditions the only way an alarm flag can drop is through a stop or a status write. The bench drives every strobe for exactly one cycle at the falling edge and never overlaps stop with a write. It raises events only in cycles where the expected value is fixed by the requirements. Event inputs stay idle between directed scenarios.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [AW-1:0] ADDR_CTRL   = 8'h08;
  localparam logic [AW-1:0] ADDR_OSC    = 8'h09;
  localparam logic [AW-1:0] ADDR_STATUS = 8'h0B;
  localparam logic [AW-1:0] CLK_REG_LAST = 8'h06;

  // Sticky flag update: set has priority over any clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic arst, input logic rsl,
                                                input logic alm, input logic bat, input logic pf);
    return {arst, 1'b0, rsl, 2'b00, alm, bat, pf};
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input logic alme, input logic lp);
    return {1'b0, alme, lp, 5'b0};
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          osc_wr,
  input  logic [DW-1:0] wdata,
  input  logic          osc_absent,
  output logic          alme_q,
  output logic          lpm_q,
  output logic          of_q,
  output logic          of_set_ev
);
  logic of_clr;
  assign of_set_ev = osc_absent;
  assign of_clr    = osc_wr & ~wdata[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alme_q <= 1'b0;
      lpm_q  <= 1'b0;
      of_q   <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        alme_q <= wdata[6];
        lpm_q  <= wdata[5];
      end
      of_q <= sticky_next(of_q, of_set_ev, of_clr);
    end
  end
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_wr,
  input  logic          sr_rd,
  input  logic          any_wr,
  input  logic          clk_reg_wr,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [DW-1:0] wdata,
  input  logic          batt_mode,
  input  logic          alarm_hit,
  input  logic          alme,
  output logic          arst_q,
  output logic          rsl_q,
  output logic          alm_q,
  output logic          bat_q,
  output logic          pf_q,
  output logic          bat_set_ev,
  output logic          alm_set_ev,
  output logic          autoclr_ev
);
  logic batt_d, armed_q, snap_alm_q, snap_bat_q;
  logic alm_clr, bat_clr;

  assign bat_set_ev = batt_mode & ~batt_d;
  assign alm_set_ev = alarm_hit & alme;
  assign autoclr_ev = armed_q & bus_stop & arst_q;
  assign alm_clr = (sr_wr & ~wdata[2]) | (autoclr_ev & snap_alm_q);
  assign bat_clr = (sr_wr & ~wdata[1]) | (autoclr_ev & snap_bat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_q     <= 1'b0;
      rsl_q      <= 1'b0;
      alm_q      <= 1'b0;
      bat_q      <= 1'b1;
      pf_q       <= 1'b1;
      batt_d     <= 1'b0;
      armed_q    <= 1'b0;
      snap_alm_q <= 1'b0;
      snap_bat_q <= 1'b0;
    end else begin
      batt_d <= batt_mode;
      if (sr_wr) begin
        arst_q <= wdata[7];
        rsl_q  <= wdata[5];
      end
      alm_q <= sticky_next(alm_q, alm_set_ev, alm_clr);
      bat_q <= sticky_next(bat_q, bat_set_ev, bat_clr);
      if (clk_reg_wr) pf_q <= 1'b0;
      if (sr_rd) begin
        armed_q    <= 1'b1;
        snap_alm_q <= alm_q;
        snap_bat_q <= bat_q;
      end else if (bus_stop || bus_start || any_wr) begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_start,
  input  logic       bus_stop,
  output logic [7:0] bus_rdata,
  input  logic       batt_mode,
  input  logic       alarm_hit,
  input  logic       osc_absent,
  output logic       clk_run,
  output logic       alarm_en,
  output logic       low_power,
  output logic       seal,
  output logic       auto_clr
);
  logic sr_wr, sr_rd, ctrl_wr, osc_wr, clk_reg_wr;
  logic arst_q, rsl_q, alm_q, bat_q, pf_q, alme_q, lpm_q, of_q;
  logic bat_set_ev, alm_set_ev, autoclr_ev, of_set_ev;

  assign sr_wr      = bus_wr & (bus_addr == ADDR_STATUS);
  assign sr_rd      = bus_rd & (bus_addr == ADDR_STATUS);
  assign ctrl_wr    = bus_wr & (bus_addr == ADDR_CTRL);
  assign osc_wr     = bus_wr & (bus_addr == ADDR_OSC);
  assign clk_reg_wr = bus_wr & (bus_addr <= CLK_REG_LAST);

  rtc_status_reg u_status (
    .clk, .rst_n, .sr_wr, .sr_rd, .any_wr(bus_wr), .clk_reg_wr,
    .bus_start, .bus_stop, .wdata(bus_wdata), .batt_mode, .alarm_hit,
    .alme(alme_q), .arst_q, .rsl_q, .alm_q, .bat_q, .pf_q,
    .bat_set_ev, .alm_set_ev, .autoclr_ev
  );

  rtc_ctrl_reg u_ctrl (
    .clk, .rst_n, .ctrl_wr, .osc_wr, .wdata(bus_wdata), .osc_absent,
    .alme_q, .lpm_q, .of_q, .of_set_ev
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_STATUS: bus_rdata = pack_status(arst_q, rsl_q, alm_q, bat_q, pf_q);
      ADDR_CTRL:   bus_rdata = pack_ctrl(alme_q, lpm_q);
      ADDR_OSC:    bus_rdata = {of_q, 7'b0};
      default:     bus_rdata = '0;
    endcase
  end

  assign clk_run   = ~pf_q;
  assign alarm_en  = alme_q;
  assign low_power = lpm_q;
  assign seal      = rsl_q;
  assign auto_clr  = arst_q;
endmodule

// File: rtl/rtc_flag_bank_chk.sv
module rtc_flag_bank_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_stop,
  input logic sr_wr,
  input logic osc_absent,
  input logic clk_run,
  input logic pf_q,
  input logic alm_q,
  input logic bat_q,
  input logic of_q,
  input logic alme_q,
  input logic bat_set_ev,
  input logic alm_set_ev
);
  AST_HALT_WHILE_FAIL: assert property (@(posedge clk) disable iff (!rst_n) pf_q |-> !clk_run); // R3
  AST_FAIL_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !pf_q |=> !pf_q); // R3
  AST_BAT_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n) (!bat_q && !bat_set_ev) |=> !bat_q); // R4
  AST_OSC_FORCES_FLAG: assert property (@(posedge clk) disable iff (!rst_n) osc_absent |=> of_q); // R5
  AST_ALARM_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!alm_q && !alme_q) |=> !alm_q); // R7
  AST_ALARM_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) alm_set_ev |=> alm_q); // R9
  AST_NO_CLEAR_WITHOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (alm_q && !bus_stop && !sr_wr) |=> alm_q); // R10
endmodule

bind rtc_flag_bank rtc_flag_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .sr_wr(sr_wr),
  .osc_absent(osc_absent), .clk_run(clk_run), .pf_q(pf_q), .alm_q(alm_q),
  .bat_q(bat_q), .of_q(of_q), .alme_q(alme_q), .bat_set_ev(bat_set_ev),
  .alm_set_ev(alm_set_ev)
);

// File: tb/rtc_flag_bank_test.sv
module rtc_flag_bank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, bus_start = 0, bus_stop = 0;
  logic batt_mode = 0, alarm_hit = 0, osc_absent = 0;
  logic clk_run, alarm_en, low_power, seal, auto_clr;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  rtc_flag_bank uut (.*);

  // {address, write data, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    {8'h08, 8'hFF, 8'h60}, {8'h08, 8'h40, 8'h40}, {8'h08, 8'h20, 8'h20},
    {8'h08, 8'h00, 8'h00}, {8'h0B, 8'hFF, 8'hA2}, {8'h0B, 8'h20, 8'h20},
    {8'h0B, 8'h02, 8'h00}, {8'h09, 8'hFF, 8'h80}, {8'h09, 8'h7F, 8'h00},
    {8'h09, 8'h80, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask

  task automatic pulse_start();
    bus_start = 1; @(negedge clk); bus_start = 0;
  endtask

  task automatic pulse_hit();
    alarm_hit = 1; @(negedge clk); alarm_hit = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset defaults
    rd(8'h0B, v); check("R1 status", v, 8'h03);
    rd(8'h09, v); check("R1 osc", v, 8'h80);
    rd(8'h08, v); check("R1 ctrl", v, 8'h00);
    rd(8'h20, v); check("R1 unused", v, 8'h00);
    check("R3 halted", {7'b0, clk_run}, 8'h00);
    // R3 non-clock write keeps halt, clock write releases it
    wr(8'h0B, 8'h03);
    check("R3 still halted", {7'b0, clk_run}, 8'h00);
    wr(8'h00, 8'h12);
    check("R3 run", {7'b0, clk_run}, 8'h01);
    rd(8'h0B, v); check("R3 pf cleared", v, 8'h02);
    pulse_start();
    // R2 R4 table walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      check($sformatf("R2/R4 vec%0d", i), v, VEC[i][7:0]);
    end
    pulse_start();
    wr(8'h0B, 8'hA0);
    check("R2 outs", {4'b0, auto_clr, seal, alarm_en, low_power}, 8'h0C);
    wr(8'h0B, 8'h00);
    // R5 oscillator flag
    osc_absent = 1; @(negedge clk);
    wr(8'h09, 8'h00);
    rd(8'h09, v); check("R5 clear blocked", v, 8'h80);
    osc_absent = 0;
    wr(8'h09, 8'h00);
    rd(8'h09, v); check("R5 clear ok", v, 8'h00);
    // R6 battery edge
    batt_mode = 1; @(negedge clk);
    rd(8'h0B, v); check("R6 set", v, 8'h02);
    wr(8'h0B, 8'h00);
    @(negedge clk);
    rd(8'h0B, v); check("R6 no re-set", v, 8'h00);
    batt_mode = 0; @(negedge clk);
    // R7 alarm gating
    pulse_hit();
    rd(8'h0B, v); check("R7 gated", v, 8'h00);
    wr(8'h08, 8'h40);
    pulse_hit();
    rd(8'h0B, v); check("R7 set", v, 8'h04);
    pulse_start();
    // R8 auto-clear
    batt_mode = 1; @(negedge clk); batt_mode = 0;
    wr(8'h0B, 8'h86);
    rd(8'h0B, v); check("R8 pre", v, 8'h86);
    pulse_stop();
    rd(8'h0B, v); check("R8 cleared", v, 8'h80);
    pulse_stop();
    // R10 repeated start disarms
    pulse_hit();
    rd(8'h0B, v); check("R10 read", v, 8'h84);
    pulse_start();
    pulse_stop();
    rd(8'h0B, v); check("R10 kept", v, 8'h84);
    pulse_stop();
    rd(8'h0B, v); check("R8 clear after", v, 8'h80);
    // R9 event between read and stop
    pulse_hit();
    pulse_stop();
    rd(8'h0B, v); check("R9 survives", v, 8'h84);
    pulse_start();
    // R9 event in same cycle as clearing write
    alarm_hit = 1; wr(8'h0B, 8'h80); alarm_hit = 0;
    rd(8'h0B, v); check("R9 beats write", v, 8'h84);
    pulse_start();
    // R8 no clear with auto-clear off
    wr(8'h0B, 8'h04);
    rd(8'h0B, v); check("R8 off read", v, 8'h04);
    pulse_stop();
    rd(8'h0B, v); check("R8 off kept", v, 8'h04);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule